// File: doc/BRIEF.md
# GPIO Interrupt Unit With Per-Pin Triggers

This block serves 32 general-purpose pins split into a low and a high bank of 16 bits each. Software reaches it through 16-bit register reads and writes at halfword offsets. For each pin it holds a direction bit, an output value, an interrupt enable, and a trigger configuration: level or edge detection, the active polarity for level mode, a hold or pass-through choice for edges, and separate rising and falling edge enables.

Pin inputs are first brought into the clock domain by two flops. Edges are found by comparing the synchronised value with its value one clock earlier. A pending status bit is raised only for enabled pins. Held edge events stay pending until software writes a one to that status bit. The block drives one combined interrupt line, and it also reports which enabled pending pin has the lowest number.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every configuration register and both status halves read zero, `irq` and `irq_idx_valid` are 0, and `pin_oe` is all zero.
- R2: A write to a mapped offset is visible on `bus_rdata` from the next clock. Offset bit 1 selects the bank: 0 is pins 0–15 and 1 is pins 16–31, pin n on bit n mod 16. The offsets are 0x00 direction, 0x04 data, 0x08 status, 0x0C enable, 0x10 trigger type, 0x14 polarity, 0x18 hold, 0x20 falling enable and 0x24 rising enable. Odd or unmapped offsets ignore writes and read 0.
- R3: `pin_oe` equals the direction bits, with 1 meaning output. `pin_out` equals the data register. A data read returns the written value for output pins and the synchronised input for input pins.
- R4: Trigger type bit 0 selects level mode. In this mode the status bit equals enable AND (synchronised pin == polarity bit), where polarity 1 is active high and 0 is active low. The status tracks the line and cannot be cleared by software while the line stays active.
- R5: In edge mode (type bit 1), a rising edge raises status only if its rising enable is 1, and a falling edge only if its falling enable is 1. With both enables set, both edges raise status.
- R6: An edge pin with hold bit 1 keeps its status at 1 until a status write has a 1 in that bit position. Writing 0 there leaves the status unchanged.
- R7: An edge pin with hold bit 0 raises status for exactly one cycle for each detected edge.
- R8: A hold bit can be 1 only on an edge pin. Writing a trigger type of 0 clears the matching hold bit.
- R9: A pin whose enable is 0 never raises its status.
- R10: `irq` is the OR of status AND enable over all pins. `irq_idx` gives the lowest-numbered pin with status AND enable set, scanning the low bank first, and `irq_idx_valid` is 0 when no such pin exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 6 | Byte offset of the addressed halfword register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output values per pin |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt request |
| irq_idx | output | 5 | Lowest enabled pending pin number |
| irq_idx_valid | output | 1 | `irq_idx` is meaningful |

## Verification
A register write takes effect at the clock edge that captures it, so the bench reads back at the falling edge that follows. A pin change passes two synchroniser flops and then the status register, so status, `irq` and the index become visible after the third rising edge. The bench therefore samples three falling edges after it drives a pin. A pass-through pulse is checked at that point and checked gone one edge later. A level pin whose polarity is changed reacts at the second edge after the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 6;

    // register group selected by offset bits [5:2]; bit 1 picks the bank
    localparam logic [3:0] GRP_DIR  = 4'd0;
    localparam logic [3:0] GRP_DATA = 4'd1;
    localparam logic [3:0] GRP_STAT = 4'd2;
    localparam logic [3:0] GRP_EN   = 4'd3;
    localparam logic [3:0] GRP_TYPE = 4'd4;
    localparam logic [3:0] GRP_POL  = 4'd5;
    localparam logic [3:0] GRP_HOLD = 4'd6;
    localparam logic [3:0] GRP_FALL = 4'd8;
    localparam logic [3:0] GRP_RISE = 4'd9;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] cur_q,
    output logic [W-1:0] prev_q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = raw_in;
        s_d.cur  = s_q.meta;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_q  = s_q.cur;
    assign prev_q = s_q.prev;

    // edge reference lags the synchronised value by exactly one clock
    a_r5_prev_lags: assert property (@(posedge clk) disable iff (!rst_n)
        prev_q == $past(cur_q));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] hold,
    input  logic [W-1:0] fen,
    input  logic [W-1:0] ren,
    input  logic [W-1:0] en,
    input  logic [W-1:0] stat_q,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat_d
);
    logic [W-1:0] rise, fall, ev, active;

    assign rise   = cur & ~prev;
    assign fall   = ~cur & prev;
    assign ev     = (rise & ren) | (fall & fen);
    assign active = ~(cur ^ pol);

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (!typ[i])
                stat_d[i] = en[i] & active[i];
            else if (hold[i])
                stat_d[i] = (stat_q[i] & ~clr[i]) | (en[i] & ev[i]);
            else
                stat_d[i] = en[i] & ev[i];
        end
    end
endmodule

// File: rtl/gpio_irq_prienc.sv
module gpio_irq_prienc #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

    a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0)));
    a_r10_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (vec == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int BANK_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BANK_W-1:0]     bus_wdata,
    output logic [BANK_W-1:0]     bus_rdata,
    input  logic [2*BANK_W-1:0]   pin_in,
    output logic [2*BANK_W-1:0]   pin_out,
    output logic [2*BANK_W-1:0]   pin_oe,
    output logic                  irq,
    output logic [$clog2(2*BANK_W)-1:0] irq_idx,
    output logic                  irq_idx_valid
);
    localparam int NPINS = 2 * BANK_W;
    localparam int IDX_W = $clog2(NPINS);

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] stat;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] typ;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] hold;
        logic [NPINS-1:0] fen;
        logic [NPINS-1:0] ren;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPINS-1:0] cur_q, prev_q, stat_nx, clr, pend;
    logic [3:0]       grp;
    logic             bank, aligned;

    assign grp     = bus_addr[5:2];
    assign bank    = bus_addr[1];
    assign aligned = !bus_addr[0];

    function automatic logic [NPINS-1:0] put_half(input logic [NPINS-1:0] cur,
                                                  input logic hi,
                                                  input logic [BANK_W-1:0] v);
        put_half = hi ? {v, cur[BANK_W-1:0]} : {cur[NPINS-1:BANK_W], v};
    endfunction

    function automatic logic [BANK_W-1:0] get_half(input logic [NPINS-1:0] v,
                                                   input logic hi);
        get_half = hi ? v[NPINS-1:BANK_W] : v[BANK_W-1:0];
    endfunction

    gpio_irq_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .cur_q  (cur_q),
        .prev_q (prev_q)
    );

    gpio_irq_detect #(.W(NPINS)) u_detect (
        .cur    (cur_q),
        .prev   (prev_q),
        .typ    (r_q.typ),
        .pol    (r_q.pol),
        .hold   (r_q.hold),
        .fen    (r_q.fen),
        .ren    (r_q.ren),
        .en     (r_q.en),
        .stat_q (r_q.stat),
        .clr    (clr),
        .stat_d (stat_nx)
    );

    // next-state: bus writes, hold pruning, status update
    always_comb begin
        r_d = r_q;
        clr = '0;
        if (bus_wr_en && aligned) begin
            case (grp)
                GRP_DIR:  r_d.dir  = put_half(r_q.dir,  bank, bus_wdata);
                GRP_DATA: r_d.dout = put_half(r_q.dout, bank, bus_wdata);
                GRP_STAT: clr      = put_half('0,       bank, bus_wdata);
                GRP_EN:   r_d.en   = put_half(r_q.en,   bank, bus_wdata);
                GRP_TYPE: r_d.typ  = put_half(r_q.typ,  bank, bus_wdata);
                GRP_POL:  r_d.pol  = put_half(r_q.pol,  bank, bus_wdata);
                GRP_HOLD: r_d.hold = put_half(r_q.hold, bank, bus_wdata);
                GRP_FALL: r_d.fen  = put_half(r_q.fen,  bank, bus_wdata);
                GRP_RISE: r_d.ren  = put_half(r_q.ren,  bank, bus_wdata);
                default:  ;
            endcase
        end
        r_d.hold = r_d.hold & r_d.typ;
        r_d.stat = stat_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read port
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (grp)
                GRP_DIR:  bus_rdata = get_half(r_q.dir, bank);
                GRP_DATA: bus_rdata = get_half((r_q.dir & r_q.dout) | (~r_q.dir & cur_q), bank);
                GRP_STAT: bus_rdata = get_half(r_q.stat, bank);
                GRP_EN:   bus_rdata = get_half(r_q.en,   bank);
                GRP_TYPE: bus_rdata = get_half(r_q.typ,  bank);
                GRP_POL:  bus_rdata = get_half(r_q.pol,  bank);
                GRP_HOLD: bus_rdata = get_half(r_q.hold, bank);
                GRP_FALL: bus_rdata = get_half(r_q.fen,  bank);
                GRP_RISE: bus_rdata = get_half(r_q.ren,  bank);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pend    = r_q.stat & r_q.en;
    assign irq     = |pend;
    assign pin_out = r_q.dout;
    assign pin_oe  = r_q.dir;

    gpio_irq_prienc #(.W(NPINS), .IDX_W(IDX_W)) u_prienc (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (pend),
        .idx   (irq_idx),
        .valid (irq_idx_valid)
    );

    a_r1_clear_after_reset: assert property (@(posedge clk)
        !rst_n |=> (r_q.en == '0 && r_q.stat == '0 && r_q.dir == '0));
    a_r8_hold_only_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hold & ~r_q.typ) == '0);
    a_r10_irq_matches_index: assert property (@(posedge clk) disable iff (!rst_n)
        irq == irq_idx_valid);
    a_r10_index_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_valid |-> (r_q.stat[irq_idx] && r_q.en[irq_idx]));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        a_r9_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (!r_q.en[i] && !r_q.stat[i]) |=> !r_q.stat[i]);
        a_r6_held_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.typ[i] && r_q.hold[i] && r_q.stat[i] && !clr[i]) |=> r_q.stat[i]);
    end
endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq, irq_idx_valid;
    logic [4:0]  irq_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .irq_idx(irq_idx),
        .irq_idx_valid(irq_idx_valid)
    );

    // {write, offset, wdata, expected readback}
    localparam logic [38:0] VEC [17] = '{
        {1'b1, 6'h02, 16'h1234, 16'h1234},
        {1'b1, 6'h02, 16'h0000, 16'h0000},
        {1'b1, 6'h14, 16'hBEEF, 16'hBEEF},
        {1'b1, 6'h16, 16'h0F0F, 16'h0F0F},
        {1'b1, 6'h10, 16'hFFFF, 16'hFFFF},
        {1'b1, 6'h18, 16'hF0F0, 16'hF0F0},
        {1'b1, 6'h10, 16'h00FF, 16'h00FF},
        {1'b0, 6'h18, 16'h0000, 16'h00F0},
        {1'b1, 6'h22, 16'h5555, 16'h5555},
        {1'b1, 6'h26, 16'hAAAA, 16'hAAAA},
        {1'b1, 6'h1C, 16'hFFFF, 16'h0000},
        {1'b1, 6'h10, 16'h0000, 16'h0000},
        {1'b0, 6'h18, 16'h0000, 16'h0000},
        {1'b1, 6'h14, 16'h0000, 16'h0000},
        {1'b1, 6'h16, 16'h0000, 16'h0000},
        {1'b1, 6'h22, 16'h0000, 16'h0000},
        {1'b1, 6'h26, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        tick(3);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "irq", {31'd0, irq}, 32'd0);
        check("R1", "idx_valid", {31'd0, irq_idx_valid}, 32'd0);
        check("R1", "pin_oe", pin_oe, 32'd0);
        rd(6'h0C, v); check("R1", "enable low", {16'd0, v}, 32'd0);
        rd(6'h0E, v); check("R1", "enable high", {16'd0, v}, 32'd0);
        rd(6'h0A, v); check("R1", "status high", {16'd0, v}, 32'd0);

        // R2 / R8 register table
        for (int k = 0; k < 17; k++) begin
            if (VEC[k][38]) wr(VEC[k][37:32], VEC[k][31:16]);
            rd(VEC[k][37:32], v);
            check(VEC[k][37:32] == 6'h18 ? "R8" : "R2", $sformatf("vector %0d", k),
                  {16'd0, v}, {16'd0, VEC[k][15:0]});
        end
        rd(6'h03, v); check("R2", "odd offset", {16'd0, v}, 32'd0);

        // R3 direction and data
        wr(6'h00, 16'h00FF);
        wr(6'h04, 16'hA5C3);
        wr(6'h06, 16'h8001);
        pin_in[15:8] = 8'h96;
        tick(3);
        check("R3", "pin_oe", pin_oe, 32'h0000_00FF);
        check("R3", "pin_out", pin_out, 32'h8001_A5C3);
        rd(6'h04, v); check("R3", "data low mixed", {16'd0, v}, 32'h96C3);
        rd(6'h06, v); check("R3", "data high input", {16'd0, v}, 32'h0000);
        pin_in = '0;
        wr(6'h00, 16'h0000);

        // R5 / R6 rising hold on pin 3
        wr(6'h10, 16'h0008); wr(6'h18, 16'h0008);
        wr(6'h24, 16'h0008); wr(6'h0C, 16'h0008);
        pin_in[3] = 1'b1; tick(3);
        rd(6'h08, v); check("R5", "rising sets pin3", {16'd0, v}, 32'h0008);
        check("R10", "irq pin3", {31'd0, irq}, 32'd1);
        check("R10", "idx pin3", {26'd0, irq_idx_valid, irq_idx}, {26'd0, 1'b1, 5'd3});
        pin_in[3] = 1'b0; tick(3);
        rd(6'h08, v); check("R6", "held across fall", {16'd0, v}, 32'h0008);
        wr(6'h08, 16'h0000);
        rd(6'h08, v); check("R6", "write zero keeps", {16'd0, v}, 32'h0008);
        wr(6'h08, 16'h0008);
        rd(6'h08, v); check("R6", "write one clears", {16'd0, v}, 32'h0000);
        check("R10", "irq after clear", {31'd0, irq}, 32'd0);

        // R9 disabled pin 5
        wr(6'h10, 16'h0028); wr(6'h18, 16'h0028); wr(6'h24, 16'h0028);
        pin_in[5] = 1'b1; tick(3);
        rd(6'h08, v); check("R9", "disabled pin5", {16'd0, v}, 32'h0000);
        check("R9", "irq disabled", {31'd0, irq}, 32'd0);
        pin_in[5] = 1'b0;

        // R7 pass-through pin 6
        wr(6'h10, 16'h0048); wr(6'h18, 16'h0008);
        wr(6'h24, 16'h0048); wr(6'h0C, 16'h0048);
        pin_in[6] = 1'b1; tick(3);
        rd(6'h08, v); check("R7", "pulse present", {16'd0, v}, 32'h0040);
        tick(1);
        rd(6'h08, v); check("R7", "pulse gone", {16'd0, v}, 32'h0000);
        pin_in[6] = 1'b0; tick(3);

        // R5 both edges held on pin 20
        wr(6'h12, 16'h0010); wr(6'h1A, 16'h0010); wr(6'h22, 16'h0010);
        wr(6'h26, 16'h0010); wr(6'h0E, 16'h0010);
        pin_in[20] = 1'b1; tick(3);
        rd(6'h0A, v); check("R5", "both: rise", {16'd0, v}, 32'h0010);
        check("R10", "idx pin20", {26'd0, irq_idx_valid, irq_idx}, {26'd0, 1'b1, 5'd20});
        wr(6'h0A, 16'h0010);
        rd(6'h0A, v); check("R6", "pin20 cleared", {16'd0, v}, 32'h0000);
        pin_in[20] = 1'b0; tick(3);
        rd(6'h0A, v); check("R5", "both: fall", {16'd0, v}, 32'h0010);
        wr(6'h0A, 16'h0010);

        // R4 level mode on pin 17, active high
        wr(6'h16, 16'h0002); wr(6'h0E, 16'h0012);
        tick(1);
        rd(6'h0A, v); check("R4", "inactive low line", {16'd0, v}, 32'h0000);
        pin_in[17] = 1'b1; tick(3);
        rd(6'h0A, v); check("R4", "active high", {16'd0, v}, 32'h0002);
        check("R10", "idx pin17", {26'd0, irq_idx_valid, irq_idx}, {26'd0, 1'b1, 5'd17});
        pin_in[3] = 1'b1; tick(3);
        check("R10", "low bank first", {26'd0, irq_idx_valid, irq_idx}, {26'd0, 1'b1, 5'd3});
        wr(6'h08, 16'h0008);
        check("R10", "back to pin17", {26'd0, irq_idx_valid, irq_idx}, {26'd0, 1'b1, 5'd17});
        pin_in[3] = 1'b0;
        wr(6'h0A, 16'h0002);
        rd(6'h0A, v); check("R4", "level ignores clear", {16'd0, v}, 32'h0002);
        pin_in[17] = 1'b0; tick(3);
        rd(6'h0A, v); check("R4", "follows line", {16'd0, v}, 32'h0000);
        check("R10", "none pending", {31'd0, irq_idx_valid}, 32'd0);
        wr(6'h16, 16'h0000); tick(1);
        rd(6'h0A, v); check("R4", "active low", {16'd0, v}, 32'h0002);

        // R8 level select drops hold
        wr(6'h12, 16'h0000);
        rd(6'h1A, v); check("R8", "hold cleared", {16'd0, v}, 32'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule